// File: doc/BRIEF.md
# Doorbell Mailbox Interrupt Register Block

This block is a small memory-mapped register window that lets two peers signal one another. A bus master reaches three registers through a slave port that carries a per-access size: byte, halfword or word. A byte store to the doorbell register is forwarded to the far peer as a single-byte message on an outbound valid/ready stream. Single bytes arriving from the far peer on an inbound stream are loaded into a 16-bit event status register. The block raises an active-high level interrupt whenever a status bit lines up with a set bit in a 16-bit enable mask.

The status register acts as a last-event mailbox. An incoming byte replaces its contents rather than accumulating into it, and a halfword read returns the value and empties the register in the same access. Only the low eight address bits take part in decoding. Word accesses and byte reads are inert.

Top module: `dbell_mailbox`

## Requirements
- R1: A synchronous active-high reset leaves the enable mask and the event status at zero, the interrupt low and no outbound message pending.
- R2: One cycle after any register change, the interrupt output equals the OR-reduction of (status AND mask). While nothing changes, it stays equal to that value.
- R3: A halfword write (size code 2'b01) whose offset, with bit 0 forced to zero, is 0x00 loads wdata[15:0] into the mask. At 0x10 it loads the status. Halfword writes at every other offset change neither register.
- R4: A halfword read returns the mask in rdata[15:0] at offsets 0x00/0x01, the status at 0x10/0x11 and zero elsewhere. The upper rdata bits are zero. A mask read or an unmapped read changes no state.
- R5: A completed halfword read at 0x10/0x11 clears the status to zero at that clock edge, and the interrupt deasserts in the same cycle as the status.
- R6: A byte write (size code 2'b00) at offset 0x20 presents wdata[7:0] on tx_data with tx_valid high from the next cycle. A byte write at any other offset sends nothing and changes no register.
- R7: A pending outbound message keeps tx_valid high and tx_data stable until a cycle with tx_ready high. A doorbell write made while a message is pending and tx_ready is low holds bus_ready low until the slot drains.
- R8: A byte received with rx_valid high replaces the status with the zero-extended rx_data at the next edge.
- R9: When a received byte and a status write or status read-clear happen in the same cycle, the status takes the received byte.
- R10: Word accesses (size code 2'b10) and byte reads change no state and return zero read data. Size code 2'b11 behaves the same way.
- R11: Address bits above bit 7 do not affect decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, completes on an edge with bus_ready high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| bus_addr | input | ADDR_W | Byte address, low 8 bits decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_req is high |
| bus_ready | output | 1 | Low only while a doorbell write is stalled |
| tx_valid | output | 1 | Outbound message pending |
| tx_data | output | 8 | Outbound message byte |
| tx_ready | input | 1 | Peer accepts the outbound byte |
| rx_valid | input | 1 | Inbound byte present (always accepted) |
| rx_data | input | 8 | Inbound byte |
| irq | output | 1 | Level interrupt, high when status AND mask is nonzero |

## Verification
The hardest case to reach from the ports is a doorbell write that lands while the previous message is still held because the peer is not ready. The bench leaves tx_ready low after a first doorbell and issues a second one. A parallel thread watches bus_ready stay low for several cycles and then releases tx_ready, after which the second byte must appear. The same-cycle collision of an inbound byte with a status read-clear is produced by raising rx_valid on the exact cycle of the halfword read. Every offset of the window is swept with each access size, using addresses whose upper bits vary.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

    localparam int DATA_W   = 32;
    localparam int REG_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int WIN_BITS = 8;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'b00,
        ACC_HALF = 2'b01,
        ACC_WORD = 2'b10,
        ACC_RSVD = 2'b11
    } acc_size_e;

    localparam logic [WIN_BITS-1:0] OFS_MASK = 8'h00;
    localparam logic [WIN_BITS-1:0] OFS_STAT = 8'h10;
    localparam logic [WIN_BITS-1:0] OFS_BELL = 8'h20;

    typedef struct packed {
        logic mask_wr;
        logic mask_rd;
        logic stat_wr;
        logic stat_rd;
        logic bell_wr;
    } reg_op_t;

    function automatic reg_op_t decode_op(
        input logic                req,
        input logic                we,
        input acc_size_e           sz,
        input logic [WIN_BITS-1:0] ofs
    );
        reg_op_t             op;
        logic [WIN_BITS-1:0] ofs_h;
        op    = '0;
        ofs_h = {ofs[WIN_BITS-1:1], 1'b0};
        if (req) begin
            unique case (sz)
                ACC_HALF: begin
                    if (we) begin
                        op.mask_wr = (ofs_h == OFS_MASK);
                        op.stat_wr = (ofs_h == OFS_STAT);
                    end else begin
                        op.mask_rd = (ofs_h == OFS_MASK);
                        op.stat_rd = (ofs_h == OFS_STAT);
                    end
                end
                ACC_BYTE: begin
                    if (we) op.bell_wr = (ofs == OFS_BELL);
                end
                default: op = '0;
            endcase
        end
        return op;
    endfunction

endpackage

// File: rtl/dbm_decode.sv
module dbm_decode
    import dbm_pkg::*;
(
    input  logic                req,
    input  logic                we,
    input  logic [1:0]          size,
    input  logic [WIN_BITS-1:0] ofs,
    output reg_op_t             op
);
    always_comb begin
        op = decode_op(req, we, acc_size_e'(size), ofs);
    end
endmodule

// File: rtl/dbm_irq_regs.sv
module dbm_irq_regs
    import dbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_op_t           op,
    input  logic [REG_W-1:0]  wdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic [REG_W-1:0]  mask_q,
    output logic [REG_W-1:0]  stat_q,
    output logic              irq_q
);
    logic [REG_W-1:0] mask_d;
    logic [REG_W-1:0] stat_d;

    always_comb begin
        mask_d = mask_q;
        stat_d = stat_q;
        if (op.mask_wr) mask_d = wdata;
        if (op.stat_wr)      stat_d = wdata;
        else if (op.stat_rd) stat_d = '0;
        if (rx_valid) stat_d = {{(REG_W-BYTE_W){1'b0}}, rx_data};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            mask_q <= mask_d;
            stat_q <= stat_d;
            irq_q  <= |(mask_d & stat_d);
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (mask_q == '0 && stat_q == '0 && !irq_q)); // R1
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst) irq_q == (|(mask_q & stat_q))); // R2
    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (rst) (op.stat_rd && !rx_valid) |=> stat_q == '0); // R5
    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst) !op.mask_wr |=> $stable(mask_q)); // R4
    AST_RX_REPLACE: assert property (@(posedge clk) disable iff (rst) rx_valid |=> stat_q == {{(REG_W-BYTE_W){1'b0}}, $past(rx_data)}); // R8
    AST_RX_WINS: assert property (@(posedge clk) disable iff (rst) (rx_valid && (op.stat_wr || op.stat_rd)) |=> stat_q[BYTE_W-1:0] == $past(rx_data)); // R9
endmodule

// File: rtl/dbm_tx_slot.sv
module dbm_tx_slot
    import dbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              busy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else if (load) begin
            tx_valid <= 1'b1;
            tx_data  <= load_data;
        end else if (tx_ready) begin
            tx_valid <= 1'b0;
        end
    end

    assign busy = tx_valid && !tx_ready;

    AST_TX_RESET: assert property (@(posedge clk) rst |=> !tx_valid); // R1
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst) (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R7
    AST_TX_LOAD: assert property (@(posedge clk) disable iff (rst) load |=> (tx_valid && tx_data == $past(load_data))); // R6
endmodule

// File: rtl/dbell_mailbox.sv
module dbell_mailbox
    import dbm_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              irq
);
    reg_op_t          op_raw;
    reg_op_t          op_fire;
    logic             tx_busy;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] stat_q;
    logic             unused_bits;

    assign unused_bits = ^{bus_addr[ADDR_W-1:WIN_BITS], bus_wdata[DATA_W-1:REG_W]};

    dbm_decode u_decode (
        .req  (bus_req),
        .we   (bus_we),
        .size (bus_size),
        .ofs  (bus_addr[WIN_BITS-1:0]),
        .op   (op_raw)
    );

    assign bus_ready = !(op_raw.bell_wr && tx_busy);
    assign op_fire   = bus_ready ? op_raw : '0;

    dbm_irq_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .op       (op_fire),
        .wdata    (bus_wdata[REG_W-1:0]),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .mask_q   (mask_q),
        .stat_q   (stat_q),
        .irq_q    (irq)
    );

    dbm_tx_slot u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (op_fire.bell_wr),
        .load_data (bus_wdata[BYTE_W-1:0]),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .busy      (tx_busy)
    );

    always_comb begin
        bus_rdata = '0;
        if (op_raw.mask_rd)      bus_rdata[REG_W-1:0] = mask_q;
        else if (op_raw.stat_rd) bus_rdata[REG_W-1:0] = stat_q;
    end

    AST_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst) (bus_req && !(bus_we == 1'b0 && bus_size == 2'b01)) |-> bus_rdata == '0); // R10
    AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (rst) (bus_req && !bus_ready) |-> (tx_valid && !tx_ready)); // R7
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst) bus_rdata[DATA_W-1:REG_W] == '0); // R4
endmodule

// File: tb/dbell_mailbox_bench.sv
module dbell_mailbox_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam logic [1:0] SZ_B = 2'b00, SZ_H = 2'b01, SZ_W = 2'b10, SZ_R = 2'b11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_req = 1'b0, bus_we = 1'b0;
    logic [1:0]    bus_size = 2'b00;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_ready, tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, irq;
    logic [7:0]    tx_data, rx_data = '0;

    int checks = 0;
    int fails = 0;
    logic [15:0] m_mask = '0, m_stat = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbell_mailbox #(.ADDR_W(AW)) u_dbell_mailbox (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the completing edge.
    task automatic bus_op(input logic we, input logic [1:0] sz, input logic [AW-1:0] a,
                          input logic [31:0] wd, output logic [31:0] rd);
        bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = wd;
        #1;
        while (!bus_ready) begin
            @(negedge clk);
            #1;
        end
        rd = bus_rdata;
        @(negedge clk);
        bus_req = 1'b0;
        rx_valid = 1'b0;
    endtask

    task automatic rx_byte(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pop_tx(input string tag, input logic [7:0] e);
        chk({tag, " tx_valid"}, 32'(tx_valid), 32'd1);
        chk({tag, " tx_data"}, 32'(tx_data), 32'(e));
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        chk({tag, " drained"}, 32'(tx_valid), 32'd0);
    endtask

    function automatic logic [15:0] model_read(input logic [7:0] off);
        if (off[7:1] == 7'h00) return m_mask;
        if (off[7:1] == 7'h08) return m_stat;
        return 16'h0;
    endfunction

    function automatic logic exp_irq();
        return |(m_mask & m_stat);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 tx_valid", 32'(tx_valid), 0);
        bus_op(0, SZ_H, 16'h0000, 0, rd); chk("R1 mask", rd, 0);
        bus_op(0, SZ_H, 16'h0010, 0, rd); chk("R1 status", rd, 0);

        // R2 interrupt combinations
        bus_op(1, SZ_H, 16'h0000, 32'h0000_0100, rd); m_mask = 16'h0100;
        bus_op(1, SZ_H, 16'h0011, 32'h0000_0001, rd); m_stat = 16'h0001;
        chk("R2 disjoint", 32'(irq), 0);
        bus_op(1, SZ_H, 16'h0010, 32'hFFFF_0101, rd); m_stat = 16'h0101;
        chk("R2 overlap", 32'(irq), 1);
        // R5 read-clear drops irq
        bus_op(0, SZ_H, 16'h0010, 0, rd);
        chk("R5 read value", rd, 32'h0101);
        chk("R5 irq dropped", 32'(irq), 0);
        bus_op(0, SZ_H, 16'h0010, 0, rd); chk("R5 cleared", rd, 0);
        m_stat = 0;
        // R8 inbound byte replaces status
        bus_op(1, SZ_H, 16'h0000, 32'h0000_00FF, rd); m_mask = 16'h00FF;
        bus_op(1, SZ_H, 16'h0010, 32'h0000_F000, rd);
        rx_byte(8'h81);
        chk("R8 irq set", 32'(irq), 1);
        bus_op(0, SZ_H, 16'h0010, 0, rd); chk("R8 replaced", rd, 32'h0081);
        // R9 inbound byte versus read-clear in same cycle
        rx_byte(8'h12);
        rx_valid = 1'b1; rx_data = 8'h33;
        bus_op(0, SZ_H, 16'h0010, 0, rd);
        chk("R9 read old", rd, 32'h0012);
        bus_op(0, SZ_H, 16'h0010, 0, rd); chk("R9 rx wins clear", rd, 32'h0033);
        // R9 inbound byte versus status write
        rx_valid = 1'b1; rx_data = 8'h44;
        bus_op(1, SZ_H, 16'h0010, 32'h0000_AAAA, rd);
        bus_op(0, SZ_H, 16'h0010, 0, rd); chk("R9 rx wins write", rd, 32'h0044);
        m_stat = 0;

        // R6/R7 doorbell stall
        bus_op(1, SZ_B, 16'h0020, 32'hFFFF_FF5A, rd);
        repeat (3) @(negedge clk);
        chk("R7 held valid", 32'(tx_valid), 1);
        chk("R7 held data", 32'(tx_data), 32'h5A);
        fork
            bus_op(1, SZ_B, 16'h7720, 32'h0000_00C3, rd);
            begin
                repeat (3) begin
                    @(negedge clk);
                    chk("R7 stalled", 32'(bus_ready), 0);
                    chk("R7 first kept", 32'(tx_data), 32'h5A);
                end
                tx_ready = 1'b1;
                @(negedge clk);
                tx_ready = 1'b0;
            end
        join
        pop_tx("R7 second", 8'hC3);

        // R3 R4 R6 R10 R11 sweep over all offsets
        for (int off = 0; off < 256; off++) begin
            logic [15:0]   v;
            logic [AW-1:0] a;
            logic [7:0]    o;
            o = 8'(off);
            v = 16'(off * 257) ^ 16'hA5C3;
            a = {8'(off * 3 + 1), o};
            bus_op(1, SZ_H, a, {16'hFFFF, v}, rd);
            if (o[7:1] == 7'h00) m_mask = v;
            if (o[7:1] == 7'h08) m_stat = v;
            chk("R2 sweep irq", 32'(irq), 32'(exp_irq()));
            bus_op(1, SZ_W, a, 32'hFFFF_FFFF, rd);
            bus_op(1, SZ_R, a, 32'h1234_5678, rd);
            bus_op(0, SZ_B, a, 0, rd); chk("R10 byte read", rd, 0);
            bus_op(0, SZ_W, a, 0, rd); chk("R10 word read", rd, 0);
            bus_op(1, SZ_B, a, {24'hFFFFFF, ~o}, rd);
            if (o == 8'h20) pop_tx("R6 doorbell", ~o);
            else chk("R6 no message", 32'(tx_valid), 0);
            bus_op(0, SZ_H, a, 0, rd);
            chk("R4 R11 read", rd, 32'(model_read(o)));
            if (o[7:1] == 7'h08) m_stat = 0;
            bus_op(0, SZ_H, 16'hFF00, 0, rd); chk("R3 mask", rd, 32'(m_mask));
            bus_op(0, SZ_H, 16'h0011, 0, rd); chk("R3 status", rd, 32'(m_stat));
            m_stat = 0;
            chk("R2 irq after", 32'(irq), 32'(exp_irq()));
        end

        // R1 reset mid-run drops pending message and clears registers
        bus_op(1, SZ_B, 16'h0020, 32'h0000_0099, rd);
        bus_op(1, SZ_H, 16'h0000, 32'h0000_FFFF, rd);
        rx_byte(8'h07);
        chk("R1 pre irq", 32'(irq), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 tx dropped", 32'(tx_valid), 0);
        chk("R1 irq low", 32'(irq), 0);
        bus_op(0, SZ_H, 16'h0000, 0, rd); chk("R1 mask zero", rd, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule